// File: doc/BRIEF.md
# Dual-Half Timer with Keyed Watchdog

This block is a memory-mapped timer with a 32-bit register interface. It holds two 32-bit count halves, a period register for each half, a timer-control register, a global-control register and a watchdog-control register. Software picks one of two modes. In general-purpose mode the low half is a free-running counter that wraps at its period. In watchdog mode the two halves form one 64-bit count, and the two periods form one 64-bit limit.

The watchdog arms only after two keyed writes arrive in a fixed order. Once it is armed, the same two-write pair restarts the count. Three events raise a one-cycle reset request: a write with the wrong key, a write out of order, or the count reaching the limit. After the pulse the watchdog stays tripped until `rst_n` is asserted.

The register bus accepts a write in every cycle, so it has no back-pressure. Read data is registered. A `tick_en` input gates every count step.

Top module: `keyed_wdog_timer`

## Requirements
- R1: Register byte offsets and read-back:
  - 0x10 is the low count and 0x14 is the high count.
  - 0x18 is the low period and 0x1C is the high period.
  - 0x20 is timer control (bits 7:0).
  - 0x24 is global control (bit 0 enables the low half, bit 1 enables the high half, bits 3:2 hold the mode).
  - 0x28 is watchdog control. It reads the last key written in bits 31:16, and bit 0 reads 1 while the watchdog is armed.
  - `bus_rdata` shows the register addressed in the previous cycle, with its value before any write in that cycle. Unmapped offsets read 0. Every register resets to 0.
- R2: A write to global control always updates the enable bits. It updates the mode field (01 = unchained 32-bit, 10 = watchdog) only when timer control reads 0 and the watchdog is neither armed nor tripped.
- R3: The low count increments on each `tick_en` cycle when all of these hold: mode is 01, enable bit 0 is set and timer-control bit 7 is set. On a tick where the low count equals the low period, it goes to 0 instead. The high count does not move in this mode.
- R4: A count register write takes effect only while timer-control bit 7 is clear and the watchdog is neither armed nor tripped. A period write is ignored while the watchdog is armed or tripped.
- R5: In mode 10, the watchdog arms when a watchdog-control write with key 0xA5C6 and bit 0 set is followed by a watchdog-control write with key 0xDA7E and bit 0 set. Arming clears the 64-bit count to 0.
- R6: If the watchdog-control write after the first key is anything other than key 0xDA7E with bit 0 set, the block returns to waiting for the first key. It does not arm and raises no reset request.
- R7: While armed, the 64-bit count {high, low} increments on each `tick_en` cycle. On a tick where it equals {high period, low period}, the block requests reset, and the count holds that value.
- R8: While armed, key 0xA5C6 followed by key 0xDA7E restarts the count from 0. The count keeps running between these two writes.
- R9: While armed, a watchdog-control write whose key is not the next expected key raises a reset request. This also applies to the write between the two restart writes.
- R10: `wd_rst_req` is high for exactly one cycle, starting in the cycle after the triggering clock edge. Several causes on the same edge give one pulse. An expiry on the same edge as the completing restart write wins.
- R11: After the pulse the watchdog is disarmed (bit 0 reads 0) and the count stops. No further pulse occurs until `rst_n` is asserted.
- R12: Watchdog-control writes made while the mode is not 10 never arm the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one step per high cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
Two watchdog functions can fall on one clock edge: expiry and the completing restart write. The bench arms with a period of 2 and issues the first restart key on a ticking cycle. After one idle tick it issues the second key exactly on the edge where the count meets the period. The expected result is one pulse, raised by the expiry, with no restart and no second pulse. A bad key that coincides with expiry is likewise judged by the reference model, which expects a single pulse.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;
  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_CNT_HI = 8'h14;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_PRD_HI = 8'h1C;
  localparam logic [7:0] OFF_TCTL   = 8'h20;
  localparam logic [7:0] OFF_GCTL   = 8'h24;
  localparam logic [7:0] OFF_WDCTL  = 8'h28;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;
  localparam logic [1:0] MODE_GP = 2'b01;
  localparam logic [1:0] MODE_WD = 2'b10;
  localparam int RUN_BIT = 7;

  typedef enum logic [2:0] {
    WD_IDLE,
    WD_ARM,
    WD_RUN,
    WD_SVC,
    WD_DEAD
  } wd_state_t;
endpackage

// File: rtl/kwd_half.sv
module kwd_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         wrap,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (inc) begin
      value <= wrap ? '0 : value + 1'b1;
    end
  end
endmodule

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
#(
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_mode,
  input  logic          wr,
  input  logic [KW-1:0] key,
  input  logic          en_bit,
  input  logic          expire,
  output wd_state_t     st,
  output logic          restart,
  output logic          rst_req
);
  localparam logic [KW-1:0] K1 = KW'(KEY_FIRST);
  localparam logic [KW-1:0] K2 = KW'(KEY_SECOND);

  wd_state_t st_d;
  logic      fire;

  always_comb begin
    st_d    = st;
    fire    = 1'b0;
    restart = 1'b0;
    unique case (st)
      WD_IDLE: if (wr && wd_mode && key == K1 && en_bit) st_d = WD_ARM;
      WD_ARM: begin
        if (wr) begin
          if (key == K2 && en_bit) begin
            st_d    = WD_RUN;
            restart = 1'b1;
          end else begin
            st_d = WD_IDLE;
          end
        end
      end
      WD_RUN, WD_SVC: begin
        if (expire) begin
          fire = 1'b1;
          st_d = WD_DEAD;
        end else if (wr) begin
          if (st == WD_RUN && key == K1) begin
            st_d = WD_SVC;
          end else if (st == WD_SVC && key == K2) begin
            st_d    = WD_RUN;
            restart = 1'b1;
          end else begin
            fire = 1'b1;
            st_d = WD_DEAD;
          end
        end
      end
      default: st_d = WD_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WD_IDLE;
      rst_req <= 1'b0;
    end else begin
      st      <= st_d;
      rst_req <= fire;
    end
  end
endmodule

// File: rtl/keyed_wdog_timer.sv
module keyed_wdog_timer
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              wd_rst_req
);
  localparam int NHALF  = 2;
  localparam int FULL_W = NHALF * HALF_W;

  logic [HALF_W-1:0] prd_q [NHALF];
  logic [HALF_W-1:0] cnt_q [NHALF];
  logic [7:0]        tcr_q;
  logic [1:0]        en_q;
  logic [1:0]        mode_q;
  logic [KEY_W-1:0]  key_q;
  logic [KEY_W-1:0]  wr_key;
  wd_state_t         st;
  logic              restart, armed, locked, expire, wd_step, gp_run, cnt_wr_ok;
  logic              wr_wd, at_limit;
  logic [FULL_W-1:0] cnt_full, prd_full;
  logic [HALF_W-1:0] cnt_lo, prd_lo;
  logic [HALF_W-1:0] rd_d;

  logic              h_load [NHALF];
  logic              h_inc  [NHALF];
  logic              h_wrap [NHALF];
  logic [HALF_W-1:0] h_val  [NHALF];

  assign wr_key    = bus_wdata[HALF_W-1 -: KEY_W];
  assign wr_wd     = bus_we && bus_addr == ADDR_W'(OFF_WDCTL);
  assign armed     = (st == WD_RUN) || (st == WD_SVC);
  assign locked    = armed || (st == WD_DEAD);
  assign cnt_full  = {cnt_q[1], cnt_q[0]};
  assign prd_full  = {prd_q[1], prd_q[0]};
  assign at_limit  = cnt_full == prd_full;
  assign expire    = armed && tick_en && at_limit;
  assign wd_step   = armed && tick_en && !at_limit && !restart;
  assign gp_run    = (mode_q == MODE_GP) && en_q[0] && tcr_q[RUN_BIT] && tick_en;
  assign cnt_wr_ok = !tcr_q[RUN_BIT] && !locked;
  assign cnt_lo    = cnt_q[0];
  assign prd_lo    = prd_q[0];

  kwd_key_seq #(.KW(KEY_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_mode (mode_q == MODE_WD),
    .wr      (wr_wd),
    .key     (wr_key),
    .en_bit  (bus_wdata[0]),
    .expire  (expire),
    .st      (st),
    .restart (restart),
    .rst_req (wd_rst_req)
  );

  // low half counts in both modes; high half carries only in watchdog mode
  assign h_inc[0]  = gp_run || wd_step;
  assign h_wrap[0] = gp_run && (cnt_q[0] == prd_q[0]);
  assign h_inc[1]  = wd_step && (&cnt_q[0]);
  assign h_wrap[1] = 1'b0;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam logic [ADDR_W-1:0] CNT_OFF = ADDR_W'(OFF_CNT_LO) + ADDR_W'(4 * h);
    localparam logic [ADDR_W-1:0] PRD_OFF = ADDR_W'(OFF_PRD_LO) + ADDR_W'(4 * h);

    assign h_load[h] = restart || (bus_we && bus_addr == CNT_OFF && cnt_wr_ok);
    assign h_val[h]  = restart ? '0 : bus_wdata;

    kwd_half #(.W(HALF_W)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (h_load[h]),
      .load_val (h_val[h]),
      .inc      (h_inc[h]),
      .wrap     (h_wrap[h]),
      .value    (cnt_q[h])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prd_q[h] <= '0;
      end else if (bus_we && bus_addr == PRD_OFF && !locked) begin
        prd_q[h] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcr_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
      key_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_W'(OFF_TCTL)) tcr_q <= bus_wdata[7:0];
      if (bus_addr == ADDR_W'(OFF_GCTL)) begin
        en_q <= bus_wdata[1:0];
        if (tcr_q == '0 && !locked) mode_q <= bus_wdata[3:2];
      end
      if (wr_wd) key_q <= wr_key;
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (bus_addr)
      ADDR_W'(OFF_CNT_LO): rd_d = cnt_q[0];
      ADDR_W'(OFF_CNT_HI): rd_d = cnt_q[1];
      ADDR_W'(OFF_PRD_LO): rd_d = prd_q[0];
      ADDR_W'(OFF_PRD_HI): rd_d = prd_q[1];
      ADDR_W'(OFF_TCTL):   rd_d = HALF_W'(tcr_q);
      ADDR_W'(OFF_GCTL):   rd_d = HALF_W'({mode_q, en_q});
      ADDR_W'(OFF_WDCTL):  rd_d = {key_q, (HALF_W - KEY_W - 1)'(0), armed};
      default:             rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_d;
  end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wd_rst_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [KEY_W-1:0]  wr_key,
  input wd_state_t         st,
  input logic [1:0]        mode_q,
  input logic [7:0]        tcr_q,
  input logic              gp_run,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] prd_lo
);
  logic tripped_q;
  logic wd_wr;

  assign wd_wr = bus_we && bus_addr == ADDR_W'(OFF_WDCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tripped_q <= 1'b0;
    else if (wd_rst_req) tripped_q <= 1'b1;
  end

  // R10
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req);

  // R11
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped_q |-> !wd_rst_req);

  // R9
  bad_key_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_RUN && wd_wr && wr_key != KEY_FIRST) |=> wd_rst_req);

  // R6
  abort_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_ARM && wd_wr && wr_key != KEY_SECOND) |=> (st == WD_IDLE && !wd_rst_req));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_GCTL) && tcr_q != '0) |=> $stable(mode_q));

  // R3
  gp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_run && cnt_lo == prd_lo) |=> cnt_lo == '0);
endmodule

bind keyed_wdog_timer kwd_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wd_rst_req (wd_rst_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .wr_key     (wr_key),
  .st         (st),
  .mode_q     (mode_q),
  .tcr_q      (tcr_q),
  .gp_run     (gp_run),
  .cnt_lo     (cnt_lo),
  .prd_lo     (prd_lo)
);

// File: tb/keyed_wdog_timer_bench.sv
module keyed_wdog_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic        we = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  keyed_wdog_timer u_keyed_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .wd_rst_req(rst_req)
  );

  always #10 clk = ~clk;

  // reference model: states 0 wait, 1 first key seen, 2 armed, 3 mid-restart, 4 tripped
  logic [63:0] m_cnt;
  logic [31:0] m_plo, m_phi, m_rd;
  logic [7:0]  m_tcr;
  logic [1:0]  m_en, m_mode;
  logic [15:0] m_key;
  int          m_st;
  logic        m_rst;

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h10: return m_cnt[31:0];
      8'h14: return m_cnt[63:32];
      8'h18: return m_plo;
      8'h1C: return m_phi;
      8'h20: return {24'h0, m_tcr};
      8'h24: return {28'h0, m_mode, m_en};
      8'h28: return {m_key, 15'h0, (m_st == 2 || m_st == 3)};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_plo = 0; m_phi = 0; m_rd = 0; m_tcr = 0;
      m_en = 0; m_mode = 0; m_key = 0; m_st = 0; m_rst = 0;
    end else begin
      bit armed, locked, hit, fire, rest, wdw;
      int nst;
      logic [63:0] ncnt;
      logic [15:0] k;
      logic [31:0] nrd;
      armed  = (m_st == 2 || m_st == 3);
      locked = armed || m_st == 4;
      hit    = armed && tick && (m_cnt == {m_phi, m_plo});
      nrd    = mread(addr);
      wdw    = we && addr == 8'h28;
      k      = wdata[31:16];
      fire = 0; rest = 0; nst = m_st;
      case (m_st)
        0: if (wdw && m_mode == 2'b10 && k == 16'hA5C6 && wdata[0]) nst = 1;
        1: if (wdw) begin
             if (k == 16'hDA7E && wdata[0]) begin nst = 2; rest = 1; end
             else nst = 0;
           end
        2, 3: begin
          if (hit) begin fire = 1; nst = 4; end
          else if (wdw) begin
            if (m_st == 2 && k == 16'hA5C6) nst = 3;
            else if (m_st == 3 && k == 16'hDA7E) begin nst = 2; rest = 1; end
            else begin fire = 1; nst = 4; end
          end
        end
        default: ;
      endcase
      ncnt = m_cnt;
      if (m_mode == 2'b01 && m_en[0] && m_tcr[7] && tick)
        ncnt[31:0] = (m_cnt[31:0] == m_plo) ? 32'h0 : m_cnt[31:0] + 1;
      if (rest) ncnt = 0;
      else if (armed && tick && !hit) ncnt = m_cnt + 1;
      if (we) begin
        case (addr)
          8'h10: if (!m_tcr[7] && !locked) ncnt[31:0] = wdata;
          8'h14: if (!m_tcr[7] && !locked) ncnt[63:32] = wdata;
          8'h18: if (!locked) m_plo = wdata;
          8'h1C: if (!locked) m_phi = wdata;
          8'h20: m_tcr = wdata[7:0];
          8'h24: begin
            m_en = wdata[1:0];
            if (m_tcr == 0 && !locked) m_mode = wdata[3:2];
          end
          8'h28: m_key = k;
          default: ;
        endcase
      end
      m_cnt = ncnt; m_st = nst; m_rst = fire; m_rd = nrd;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata == m_rd, "R1", rdata, m_rd);
      chk(rst_req == m_rst, "R10", rst_req, m_rst);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      chk(0, "watchdog", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; we = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] prd);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'hB);
    wr(8'h18, prd);
    wr(8'h28, 32'hA5C6_0001);
    wr(8'h28, 32'hDA7E_0001);
  endtask

  initial begin
    logic [31:0] v;
    bit seen;
    do_reset();
    // R1 reset values and map
    for (int i = 0; i < 12; i++) begin
      rd(8'(i * 4), v);
      chk(v == 0, "R1", v, 0);
    end
    wr(8'h18, 32'd3);
    rd(8'h18, v); chk(v == 3, "R1", v, 3);
    // R3 general-purpose count with wrap at period 3
    wr(8'h24, 32'h5);
    wr(8'h20, 32'h80);
    tick = 1'b1;
    repeat (6) @(negedge clk);
    tick = 1'b0;
    rd(8'h10, v); chk(v == 2, "R3", v, 2);
    rd(8'h14, v); chk(v == 0, "R3", v, 0);
    // R2 mode write ignored while timer control nonzero
    wr(8'h24, 32'h9);
    rd(8'h24, v); chk(v == 32'h5, "R2", v, 32'h5);
    // R4 count write ignored while running
    wr(8'h10, 32'h1234);
    rd(8'h10, v); chk(v == 2, "R4", v, 2);
    // R12 keys in general-purpose mode do not arm
    wr(8'h28, 32'hA5C6_0001);
    wr(8'h28, 32'hDA7E_0001);
    rd(8'h28, v); chk(v == 32'hDA7E_0000, "R12", v, 32'hDA7E_0000);
    // R6 broken arming sequence
    wr(8'h20, 32'h0);
    wr(8'h24, 32'hB);
    rd(8'h24, v); chk(v == 32'hB, "R2", v, 32'hB);
    wr(8'h10, 32'd7);
    wr(8'h28, 32'hA5C6_0001);
    wr(8'h28, 32'h1234_0001);
    chk(rst_req == 0, "R6", rst_req, 0);
    rd(8'h28, v); chk(v == 32'h1234_0000, "R6", v, 32'h1234_0000);
    // R5 arming clears the count
    arm(32'd20);
    rd(8'h28, v); chk(v == 32'hDA7E_0001, "R5", v, 32'hDA7E_0001);
    rd(8'h10, v); chk(v == 0, "R5", v, 0);
    // R4 period locked while armed
    wr(8'h18, 32'd5);
    rd(8'h18, v); chk(v == 20, "R4", v, 20);
    // R8 restart pair
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    wr(8'h28, 32'hA5C6_0000);
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h10, v); chk(v == 0, "R8", v, 0);
    // R7 expiry
    tick = 1'b1;
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
    chk(seen, "R7", seen, 1);
    @(negedge clk);
    chk(rst_req == 0, "R10", rst_req, 0);
    rd(8'h10, v); chk(v == 20, "R7", v, 20);
    // R11 tripped: no re-fire, disarmed
    wr(8'h28, 32'hBEEF_0001);
    @(negedge clk);
    chk(rst_req == 0, "R11", rst_req, 0);
    rd(8'h28, v); chk(v == 32'hBEEF_0000, "R11", v, 32'hBEEF_0000);
    tick = 1'b0;
    // R9 bad key while armed
    do_reset();
    arm(32'd100);
    wr(8'h28, 32'hBEEF_0001);
    chk(rst_req == 1, "R9", rst_req, 1);
    // R9 wrong key between restart writes
    do_reset();
    arm(32'd100);
    wr(8'h28, 32'hA5C6_0001);
    chk(rst_req == 0, "R9", rst_req, 0);
    wr(8'h28, 32'hA5C6_0001);
    chk(rst_req == 1, "R9", rst_req, 1);
    // R10 expiry coincides with completing restart write
    do_reset();
    arm(32'd2);
    tick = 1'b1;
    wr(8'h28, 32'hA5C6_0001);
    @(negedge clk);
    wr(8'h28, 32'hDA7E_0001);
    chk(rst_req == 1, "R10", rst_req, 1);
    @(negedge clk);
    chk(rst_req == 0, "R10", rst_req, 0);
    tick = 1'b0;
    rd(8'h28, v); chk(v[0] == 0, "R11", v[0], 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule